// File: doc/BRIEF.md
# LED Data Line Decoder

This block listens to a single-wire, self-clocked LED data stream and turns it back into pixel data. Each bit on the wire starts with a rising edge. The share of the bit time spent high carries the value: a short high means 0 and a long high means 1. The decoder measures every bit against the system clock and reports each recovered bit as it is decided. It packs the bits into pixel words of eight bits per colour channel. It also reports the long low gaps that separate frames.

A bit is only known once the following rising edge closes its period, so bit reports trail the wire by one bit time. The last bit of a frame is different: it is closed by a reset gap rather than by a rising edge. That bit is judged against half the previous bit's period. When it is the only bit of its frame, it is judged against a fixed short threshold instead. A frame that ends part-way through a pixel word discards the unfinished word and flags the loss.

Top module: `led_line_decoder`

## Requirements
- R1: During reset and right after it, every output is low. A line that is already high when reset is released produces no edge and no bit until the line has been seen low.
- R2: A bit that is followed by another rising edge is reported with a one-cycle `bit_vld_o` when that next rising edge arrives. Its value is 1 exactly when twice its high time exceeds its period (rising edge to rising edge). Equal high and low times give 0.
- R3: After a falling edge, a low level lasting more than GAP_CYC = round(CLK_HZ × 50e-6) + 1 cycles raises a one-cycle `gap_o`. The pulse is seen at the port GAP_CYC + 3 cycles after `line_i` falls: two synchroniser stages plus one output register.
- R4: A rising edge that arrives within GAP_CYC cycles of the falling edge cancels the pending gap check, and decoding goes on normally. A low of exactly GAP_CYC cycles raises no gap, while a low of GAP_CYC + 1 cycles does.
- R5: The last bit before a gap, when an earlier bit of the same frame exists, is 1 exactly when twice its high time is at least that earlier bit's period. It is reported in the same cycle as `gap_o`.
- R6: The last bit before a gap, when it is the only bit of its frame, is 1 exactly when its high time is at least SHORT_THR = floor(CLK_HZ × 625e-9) cycles.
- R7: A gap clears the stored bit period, so the timing of one frame never affects how the next frame's bits are judged.
- R8: A pixel word holds 8 × CHANNELS bits, and the first bit received sits at the MSB. `pix_vld_o` pulses for one cycle, exactly one cycle after the `bit_vld_o` of the word's final bit.
- R9: When a gap arrives with part of a word collected, that partial word is discarded and `drop_o` pulses for one cycle, one cycle after `gap_o`. The next frame's word starts empty. A gap that follows a completed word raises no `drop_o`.
- R10: If the line is held low after power-up for longer than the gap window, a gap is reported and no bit is reported.
- R11: The high-time and period counters are CNT_W = clog2(GAP_CYC + 1) bits wide and saturate at their maximum instead of wrapping. A high phase longer than that maximum still decodes as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | LED data line, asynchronous to clk_i |
| bit_vld_o | output | 1 | One-cycle strobe for a decided bit |
| bit_o | output | 1 | Value of the decided bit |
| pix_o | output | 8*CHANNELS | Last completed pixel word, first bit at MSB |
| pix_vld_o | output | 1 | One-cycle strobe for a completed pixel word |
| gap_o | output | 1 | One-cycle strobe for a detected reset gap |
| drop_o | output | 1 | One-cycle strobe for a partial word discarded at a gap |

## Verification
The bench sweeps high and low times across the decision point, including equal high and low times. A strict-versus-inclusive slip there would flip bits in the middle of a frame. It probes the last-bit rule on both sides of half the previous period and of the fixed threshold. It also sends a single-bit frame right after a frame with a long period, so a decoder that keeps the old period across a gap misjudges that bit. Lows of exactly GAP_CYC and GAP_CYC + 1 cycles separate an off-by-one gap window from a correct one. A high phase longer than the counter range exposes a wrapping counter, which would read a long pulse as a short 0.

// File: rtl/led_dec_pkg.sv
`timescale 1ns/1ps
package led_dec_pkg;

  // cycles of low after a falling edge that make a gap: round(hz*50us)+1
  function automatic int gap_cycles(input longint unsigned hz);
    return int'((hz * 64'd50 + 64'd500000) / 64'd1000000 + 64'd1);
  endfunction

  // fixed high-time threshold for a lone last bit: floor(hz*625ns)
  function automatic int short_thr(input longint unsigned hz);
    return int'((hz * 64'd625) / 64'd1000000000);
  endfunction

endpackage

// File: rtl/led_line_sync.sv
`timescale 1ns/1ps
module led_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic s_o,
  output logic rise_o,
  output logic fall_o
);
  // STAGES synchroniser flops plus one history flop; reset high so a
  // line idle-high at release shows no edge
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign s_o    = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];

endmodule

// File: rtl/led_bit_timer.sv
`timescale 1ns/1ps
module led_bit_timer #(
  parameter int unsigned CNT_W     = 14,
  parameter int unsigned GAP_CYC   = 10001,
  parameter int unsigned SHORT_THR = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic bit_vld_o,
  output logic bit_o,
  output logic gap_o
);
  logic             armed_q, in_bit_q, have_fall_q, have_prev_q, chk_q;
  logic [CNT_W-1:0] per_q, hi_q, prev_q, low_q;

  logic             rise_ok, close_rise, gap_hit, close_gap;
  logic             val_rise, val_gap;
  logic [CNT_W:0]   hi2, per_x, prev_x;

  assign hi2    = {hi_q, 1'b0};
  assign per_x  = {1'b0, per_q};
  assign prev_x = {1'b0, prev_q};

  assign rise_ok    = rise_i & armed_q;
  assign close_rise = rise_ok & in_bit_q & have_fall_q;
  assign gap_hit    = chk_q & ~s_i & (low_q == CNT_W'(GAP_CYC));
  assign close_gap  = gap_hit & in_bit_q & have_fall_q;

  assign val_rise = hi2 > per_x;
  assign val_gap  = have_prev_q ? (hi2 >= prev_x) : (hi_q >= CNT_W'(SHORT_THR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_vld_o   <= 1'b0;
      bit_o       <= 1'b0;
      gap_o       <= 1'b0;
      armed_q     <= 1'b0;
      in_bit_q    <= 1'b0;
      have_fall_q <= 1'b0;
      have_prev_q <= 1'b0;
      chk_q       <= 1'b0;
      per_q       <= '0;
      hi_q        <= '0;
      prev_q      <= '0;
      low_q       <= '0;
    end else begin
      bit_vld_o <= close_rise | close_gap;
      bit_o     <= close_rise ? val_rise : (close_gap & val_gap);
      gap_o     <= gap_hit;

      // period counter, saturating
      if (rise_ok)                      per_q <= CNT_W'(1);
      else if (in_bit_q && per_q != '1) per_q <= per_q + 1'b1;

      if (fall_i && in_bit_q && !have_fall_q) begin
        hi_q        <= per_q;
        have_fall_q <= 1'b1;
      end

      // low-time window; first low after power-up also opens it
      if ((fall_i && armed_q) || (!armed_q && !s_i)) begin
        armed_q <= 1'b1;
        chk_q   <= 1'b1;
        low_q   <= CNT_W'(1);
      end else if (chk_q && low_q != '1) begin
        low_q <= low_q + 1'b1;
      end

      if (rise_ok) begin
        in_bit_q    <= 1'b1;
        have_fall_q <= 1'b0;
        chk_q       <= 1'b0;
        if (close_rise) begin
          prev_q      <= per_q;
          have_prev_q <= 1'b1;
        end
      end

      if (gap_hit) begin
        chk_q       <= 1'b0;
        in_bit_q    <= 1'b0;
        have_fall_q <= 1'b0;
        have_prev_q <= 1'b0;
      end
    end
  end

  // R3: a gap is only reported while the line was low
  p_gap_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_o |-> $past(!s_i));

  // R2: outside a gap, a bit is only decided on a rising edge
  p_bit_on_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_o && !gap_o) |-> $past(rise_i));

  // R4: one gap per low period, never two in a row
  p_gap_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_o |=> !gap_o);

endmodule

// File: rtl/led_pixel_packer.sv
`timescale 1ns/1ps
module led_pixel_packer #(
  parameter int unsigned PIX_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  input  logic             gap_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             pix_vld_o,
  output logic             drop_o
);
  localparam int unsigned CW = $clog2(PIX_W);

  logic [CW-1:0]    cnt_q, cnt_add;
  logic [PIX_W-1:0] sh_q, sh_nx;
  logic             full;

  assign full    = bit_vld_i && (cnt_q == CW'(PIX_W - 1));
  assign cnt_add = bit_vld_i ? cnt_q + 1'b1 : cnt_q;
  assign sh_nx   = bit_vld_i ? {sh_q[PIX_W-2:0], bit_i} : sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      sh_q      <= '0;
      pix_o     <= '0;
      pix_vld_o <= 1'b0;
      drop_o    <= 1'b0;
    end else begin
      pix_vld_o <= full;
      if (full) pix_o <= sh_nx;
      drop_o <= gap_i && !full && (cnt_add != '0);
      if (gap_i || full) begin
        cnt_q <= '0;
        sh_q  <= '0;
      end else begin
        cnt_q <= cnt_add;
        sh_q  <= sh_nx;
      end
    end
  end

  // R8: a word completes only on a bit strobe
  p_word_after_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_vld_o |-> $past(bit_vld_i));

  // R9: a drop follows a gap and never coincides with a word
  p_drop_on_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> ($past(gap_i) && !pix_vld_o));

endmodule

// File: rtl/led_line_decoder.sv
`timescale 1ns/1ps
module led_line_decoder #(
  parameter int unsigned CLK_HZ      = 200_000_000,
  parameter int unsigned CHANNELS    = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    line_i,
  output logic                    bit_vld_o,
  output logic                    bit_o,
  output logic [8*CHANNELS-1:0]   pix_o,
  output logic                    pix_vld_o,
  output logic                    gap_o,
  output logic                    drop_o
);
  localparam int unsigned GAP_CYC   = led_dec_pkg::gap_cycles(CLK_HZ);
  localparam int unsigned SHORT_THR = led_dec_pkg::short_thr(CLK_HZ);
  localparam int unsigned CNT_W     = $clog2(GAP_CYC + 1);
  localparam int unsigned PIX_W     = 8 * CHANNELS;

  logic s, rise, fall;

  led_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (line_i),
    .s_o    (s),
    .rise_o (rise),
    .fall_o (fall)
  );

  led_bit_timer #(
    .CNT_W     (CNT_W),
    .GAP_CYC   (GAP_CYC),
    .SHORT_THR (SHORT_THR)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .s_i       (s),
    .rise_i    (rise),
    .fall_i    (fall),
    .bit_vld_o (bit_vld_o),
    .bit_o     (bit_o),
    .gap_o     (gap_o)
  );

  led_pixel_packer #(.PIX_W(PIX_W)) u_pack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_vld_i (bit_vld_o),
    .bit_i     (bit_o),
    .gap_i     (gap_o),
    .pix_o     (pix_o),
    .pix_vld_o (pix_vld_o),
    .drop_o    (drop_o)
  );

endmodule

// File: tb/tb_led_line_decoder.sv
`timescale 1ns/1ps
module tb_led_line_decoder;
  localparam int unsigned HZ  = 20_000_000;
  localparam int unsigned CH  = 3;
  localparam int          PW  = 24;
  localparam int          GAP = 1001; // round(20e6*50e-6)+1
  localparam int          THR = 12;   // floor(20e6*625e-9)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b1;
  logic bit_vld, bit_v, pix_vld, gap, drop;
  logic [PW-1:0] pix;

  led_line_decoder #(.CLK_HZ(HZ), .CHANNELS(CH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line),
    .bit_vld_o(bit_vld), .bit_o(bit_v), .pix_o(pix), .pix_vld_o(pix_vld),
    .gap_o(gap), .drop_o(drop)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int bq[$];
  int bcyc[$];
  logic [PW-1:0] wq[$];
  int wcyc[$];
  int gaps = 0, drops = 0, gap_cyc = 0;

  always @(negedge clk) if (rst_n) begin
    if (bit_vld) begin bq.push_back(int'(bit_v)); bcyc.push_back(cyc); end
    if (pix_vld) begin wq.push_back(pix); wcyc.push_back(cyc); end
    if (gap) begin gaps++; gap_cyc = cyc; end
    if (drop) drops++;
  end

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    line = v;
    repeat (n) @(negedge clk);
  endtask

  int fh[0:255];
  int fl[0:255];
  int eb[0:255];

  // sends fh/fl[0..n-1]; last bit closed by a long low
  task automatic send_frame(input int n, input string last_req, input string gap_req);
    int g0, d0, fall_c, nw;
    logic [PW-1:0] w;
    bq.delete(); bcyc.delete(); wq.delete(); wcyc.delete();
    g0 = gaps; d0 = drops;
    for (int i = 0; i < n - 1; i++) begin
      drive(1'b1, fh[i]);
      drive(1'b0, fl[i]);
    end
    drive(1'b1, fh[n-1]);
    line = 1'b0;
    fall_c = cyc;
    repeat (GAP + 12) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (i < n - 1)  eb[i] = (fh[i] > fl[i]) ? 1 : 0;
      else if (i > 0) eb[i] = (2 * fh[i] >= fh[i-1] + fl[i-1]) ? 1 : 0;
      else            eb[i] = (fh[i] >= THR) ? 1 : 0;
    end
    check(gaps == g0 + 1, gap_req, "gap count", gaps - g0, 1);
    check(gap_cyc - fall_c == GAP + 3, "R3", "gap latency", gap_cyc - fall_c, GAP + 3);
    check(bq.size() == n, "R2", "bit count", bq.size(), n);
    if (bq.size() == n) begin
      for (int i = 0; i < n; i++)
        check(bq[i] == eb[i], (i < n - 1) ? "R2" : last_req, $sformatf("bit %0d", i), bq[i], eb[i]);
      check(bcyc[n-1] == gap_cyc, "R5", "last bit with gap", bcyc[n-1], gap_cyc);
      nw = n / PW;
      check(wq.size() == nw, "R8", "word count", wq.size(), nw);
      if (wq.size() == nw) begin
        for (int k = 0; k < nw; k++) begin
          w = '0;
          for (int j = 0; j < PW; j++) w = {w[PW-2:0], eb[k*PW+j][0]};
          check(wq[k] == w, "R8", $sformatf("word %0d", k), wq[k], w);
          check(wcyc[k] == bcyc[k*PW+PW-1] + 1, "R8", "word timing", wcyc[k], bcyc[k*PW+PW-1] + 1);
        end
      end
    end
    check(drops - d0 == ((n % PW) != 0 ? 1 : 0), "R9", "drop count", drops - d0, (n % PW) != 0);
  endtask

  task automatic load_word(input logic [PW-1:0] v, input int base);
    for (int j = 0; j < PW; j++) begin
      fh[base+j] = v[PW-1-j] ? 10 : 5;
      fl[base+j] = v[PW-1-j] ? 5 : 10;
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int n, g0, c0;
    repeat (5) @(negedge clk);
    check({bit_vld, pix_vld, gap, drop, pix} == '0, "R1", "reset outputs", {bit_vld, pix_vld, gap, drop}, 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    check(bq.size() == 0 && gaps == 0, "R1", "idle high", bq.size() + gaps, 0);

    // power-up low
    line = 1'b0; c0 = cyc;
    repeat (GAP + 20) @(negedge clk);
    check(gaps == 1, "R10", "power-up gap", gaps, 1);
    check(gap_cyc - c0 == GAP + 3, "R10", "power-up gap latency", gap_cyc - c0, GAP + 3);
    check(bq.size() == 0 && drops == 0, "R10", "no bit or drop", bq.size() + drops, 0);

    // R2 sweep of high/low times
    n = 0;
    for (int h = 3; h <= 16; h++)
      for (int l = 3; l <= 16; l++) begin fh[n] = h; fl[n] = l; n++; end
    fh[n] = 14; n++;
    send_frame(n, "R5", "R3");

    // R8 full words, no drop
    load_word(24'hA5C3F0, 0);
    send_frame(24, "R5", "R3");
    load_word(24'h5A0F81, 0);
    load_word(24'h3C96E7, 24);
    send_frame(48, "R5", "R3");

    // R9 partial, then a fresh word
    load_word(24'hFFFFFF, 0);
    send_frame(10, "R5", "R9");
    load_word(24'h0123AB, 0);
    send_frame(24, "R5", "R9");

    // R5 boundary around half the previous period (24)
    for (int h = 9; h <= 14; h++) begin
      fh[0] = 6; fl[0] = 18; fh[1] = h;
      send_frame(2, "R5", "R3");
    end

    // R6 lone bit around fixed threshold
    for (int h = 8; h <= 16; h++) begin
      fh[0] = h;
      send_frame(1, "R6", "R3");
    end

    // R7 long previous period must not carry into the next frame
    fh[0] = 30; fl[0] = 30; fh[1] = 5;
    send_frame(2, "R5", "R3");
    fh[0] = 20;
    send_frame(1, "R7", "R7");

    // R4 low of exactly GAP is no gap
    fh[0] = 5; fl[0] = GAP; fh[1] = 9; fl[1] = 3; fh[2] = 7;
    send_frame(3, "R5", "R4");

    // R4 low of GAP+1 is a gap
    g0 = gaps; bq.delete();
    drive(1'b1, 6); drive(1'b0, GAP + 1);
    drive(1'b1, 6); drive(1'b0, GAP + 12);
    check(gaps - g0 == 2, "R4", "gap at GAP+1", gaps - g0, 2);
    check(bq.size() == 2, "R4", "bits around gap", bq.size(), 2);

    // R11 high longer than counter range still reads as 1
    fh[0] = 1029;
    send_frame(1, "R11", "R3");

    finish_run();
  end
endmodule